// File: doc/BRIEF.md
# Edge Timestamper

The block records the arrival time of rising edges on an asynchronous reference input. A free-running counter advances once per prescaled tick and wraps to zero at a programmable maximum. Each qualified rising edge on the input copies the counter value into a capture register. Before an edge can count as qualified, the input is synchronised and passed through a glitch filter. The filter changes its output only after a programmable number of consecutive samples that differ from its current output.

Software collects timestamps with a one-cycle read strobe. The block answers in the following cycle with three things. It reports whether a fresh capture was waiting. It reports whether an unread capture was overwritten. It returns the timestamp, which is the newest value. An overwrite does not discard the newest value; it only marks it with an error. Captures are gated by an enable bit. Edges that arrive while the channel is disabled leave no trace.

Top module: `edge_timestamper`

## Requirements
- R1: The counter holds 0 after reset. It steps once every cfg_psc+1 clocks. The step after the counter reaches cfg_arr returns it to 0. Otherwise a step adds 1.
- R2: A qualified rising edge stores a timestamp. Let the input change just before clock edge 1, and let L be the effective filter length. The stored value is the counter value present just before clock edge L+2.
- R3: L equals cfg_filt_len, and a value of 0 acts as 1. A high level on the input produces a capture only if it lasts at least L consecutive clock samples. Any shorter pulse produces no capture.
- R4: A falling edge of the filtered input never produces a capture.
- R5: rd_stb sampled high at a clock edge raises rd_ack for exactly the next cycle. If no capture was waiting, the response is rd_hit=0, rd_err=0 and rd_data=0.
- R6: A read with exactly one unread capture returns rd_hit=1, rd_err=0 and rd_data equal to that timestamp. The read then clears the waiting state.
- R7: A capture that lands while an earlier capture is unread sets the over-capture condition. The next read returns rd_hit=1, rd_err=1 and the newest timestamp, and then clears both conditions.
- R8: A read and a capture may occur at the same clock edge. The read returns the older value, with rd_err=0. The new capture stays waiting and is not counted as an over-capture.
- R9: While cfg_en is 0, input edges produce no capture. Captures resume once cfg_en is 1.
- R10: While rst_n is low and after it is released, rd_ack, rd_hit, rd_err and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Asynchronous reference input to timestamp |
| cfg_psc | input | PSC_W | Prescale: counter steps every cfg_psc+1 clocks |
| cfg_arr | input | CNT_W | Largest counter value before wrap |
| cfg_en | input | 1 | Capture enable |
| cfg_filt_len | input | FLT_W | Consecutive samples needed to accept a level change |
| rd_stb | input | 1 | Read strobe, one clock wide |
| rd_ack | output | 1 | High for the cycle after a read |
| rd_hit | output | 1 | A fresh capture was returned |
| rd_err | output | 1 | Over-capture occurred before this read |
| rd_data | output | CNT_W | Returned timestamp, 0 when rd_hit is 0 |

## Verification
Single pulses are used with several widths. Pulses exactly L samples wide, and pulses one sample shorter, separate a correct filter length from an off-by-one error. Long pulses show that the falling edge is inert. Back-to-back pulses without a read separate an overwrite that keeps the newest value from one that keeps the oldest. A read timed onto the capture edge separates capture-over-read priority from the reverse. Random widths under small prescale and wrap settings make the timestamps cross the wrap point, which exposes stepping and wrap errors in the counter.

// File: rtl/ts_pkg.sv
`timescale 1ns/1ps
// Shared types for the edge timestamper.
package ts_pkg;

    // Response captured on each read strobe.
    typedef struct packed {
        logic ack;
        logic hit;
        logic err;
    } rd_status_t;

    // Filter length with zero mapped to one.
    function automatic int unsigned eff_len(input int unsigned raw);
        return (raw == 0) ? 1 : raw;
    endfunction

endpackage

// File: rtl/ts_input_qualifier.sv
`timescale 1ns/1ps
// Input qualifier: synchroniser chain, run-length glitch filter and rising-edge pulse.
// Assumes: SYNC_STAGES >= 2; filt_len is static while edges are in flight.
// The rise pulse is combinational and marks the clock edge where the filtered level goes high.
module ts_input_qualifier #(
    parameter int FLT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_async,
    input  logic [FLT_W-1:0] filt_len,
    output logic             level,
    output logic             rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    logic                   level_q;
    logic [FLT_W-1:0]       run_q;
    logic [FLT_W:0]         run_next;
    logic [FLT_W:0]         len_eff;
    logic                   accept;

    // Shift the raw input through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din_async};
    end

    assign smp      = sync_q[SYNC_STAGES-1];
    assign run_next = {1'b0, run_q} + 1'b1;
    assign len_eff  = (filt_len == '0) ? (FLT_W+1)'(1) : {1'b0, filt_len};
    assign accept   = (smp != level_q) && (run_next >= len_eff);

    // Count consecutive differing samples and flip the level once enough are seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (smp == level_q) begin
            run_q   <= '0;
        end else if (accept) begin
            level_q <= smp;
            run_q   <= '0;
        end else begin
            run_q   <= run_next[FLT_W-1:0];
        end
    end

    assign level = level_q;
    assign rise  = accept & smp;

endmodule

// File: rtl/ts_tick_counter.sv
`timescale 1ns/1ps
// Prescaled free-running counter with programmable wrap value.
// Assumes: psc and arr change only while the block is held in reset.
module ts_tick_counter #(
    parameter int CNT_W = 32,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] arr,
    output logic             tick,
    output logic [CNT_W-1:0] count
);
    logic [PSC_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick = (pre_q >= psc);

    // Advance the prescaler; step or wrap the main counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= (cnt_q >= arr) ? '0 : cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/ts_capture_unit.sv
`timescale 1ns/1ps
// Capture register with pending and over-capture flags and a registered read response.
// A capture at the same edge as a read wins for the pending flag; the read returns the older value.
module ts_capture_unit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_fire,
    input  logic [CNT_W-1:0] count,
    input  logic             rd_stb,
    output ts_pkg::rd_status_t status,
    output logic [CNT_W-1:0] rd_data,
    output logic             pend,
    output logic             ovr
);
    logic [CNT_W-1:0] cap_q;
    logic             pend_q;
    logic             ovr_q;

    // Latch the counter on each enabled qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (cap_fire) cap_q <= count;
    end

    // Track unread and overwritten captures; capture has priority over read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (cap_fire)    pend_q <= 1'b1;
            else if (rd_stb) pend_q <= 1'b0;
            if (cap_fire && pend_q && !rd_stb) ovr_q <= 1'b1;
            else if (rd_stb)                   ovr_q <= 1'b0;
        end
    end

    // Build the read response from the state before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= '0;
            rd_data <= '0;
        end else begin
            status.ack <= rd_stb;
            if (rd_stb) begin
                status.hit <= pend_q;
                status.err <= ovr_q;
                rd_data    <= pend_q ? cap_q : '0;
            end
        end
    end

    assign pend = pend_q;
    assign ovr  = ovr_q;

endmodule

// File: rtl/edge_timestamper.sv
`timescale 1ns/1ps
// Top of the edge timestamper.
// Connects the qualifier, the counter and the capture unit, and gates captures with cfg_en.
// Assumes: configuration except cfg_en is changed only during reset.
module edge_timestamper #(
    parameter int CNT_W       = 32,
    parameter int PSC_W       = 16,
    parameter int FLT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [PSC_W-1:0] cfg_psc,
    input  logic [CNT_W-1:0] cfg_arr,
    input  logic             cfg_en,
    input  logic [FLT_W-1:0] cfg_filt_len,
    input  logic             rd_stb,
    output logic             rd_ack,
    output logic             rd_hit,
    output logic             rd_err,
    output logic [CNT_W-1:0] rd_data
);
    logic               filt_level;
    logic               edge_rise;
    logic               tick;
    logic [CNT_W-1:0]   count;
    logic               cap_fire;
    logic               pend;
    logic               ovr;
    ts_pkg::rd_status_t status;

    ts_input_qualifier #(.FLT_W(FLT_W), .SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk(clk), .rst_n(rst_n), .din_async(ref_in), .filt_len(cfg_filt_len),
        .level(filt_level), .rise(edge_rise)
    );

    ts_tick_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .psc(cfg_psc), .arr(cfg_arr),
        .tick(tick), .count(count)
    );

    assign cap_fire = edge_rise & cfg_en;

    ts_capture_unit #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .count(count),
        .rd_stb(rd_stb), .status(status), .rd_data(rd_data),
        .pend(pend), .ovr(ovr)
    );

    assign rd_ack = status.ack;
    assign rd_hit = status.hit;
    assign rd_err = status.err;

endmodule

// File: rtl/ts_checker.sv
`timescale 1ns/1ps
// Assertion checker bound to edge_timestamper.
module ts_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [CNT_W-1:0] cfg_arr,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             cap_fire,
    input logic             pend,
    input logic             ovr,
    input logic             rd_stb,
    input logic             rd_ack,
    input logic             rd_hit,
    input logic             rd_err,
    input logic [CNT_W-1:0] rd_data
);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (count < cfg_arr) |=> count == $past(count) + 1'b1);

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (count == cfg_arr) |=> count == '0);

    p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_ack);

    p_ack_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_ack);

    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !rd_hit |-> (rd_data == '0) && !rd_err);

    p_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && pend |=> rd_hit);

    p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire && pend && !rd_stb |=> ovr);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !cap_fire |=> !pend && !ovr);

    p_err_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && rd_err |-> rd_hit);

    p_same_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && cap_fire |=> pend && !ovr);

    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en && !pend |=> !pend);

endmodule

bind edge_timestamper ts_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_arr(cfg_arr),
    .tick(tick), .count(count), .cap_fire(cap_fire), .pend(pend), .ovr(ovr),
    .rd_stb(rd_stb), .rd_ack(rd_ack), .rd_hit(rd_hit), .rd_err(rd_err),
    .rd_data(rd_data)
);

// File: tb/edge_timestamper_tb.sv
`timescale 1ns/1ps
module edge_timestamper_tb;
    localparam int CNT_W = 32;
    localparam int PSC_W = 16;
    localparam int FLT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_in = 1'b0;
    logic [PSC_W-1:0] cfg_psc = '0;
    logic [CNT_W-1:0] cfg_arr = 32'd1000;
    logic             cfg_en = 1'b0;
    logic [FLT_W-1:0] cfg_filt_len = 4'd8;
    logic             rd_stb = 1'b0;
    logic             rd_ack, rd_hit, rd_err;
    logic [CNT_W-1:0] rd_data;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    edge_timestamper #(.CNT_W(CNT_W), .PSC_W(PSC_W), .FLT_W(FLT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .cfg_psc(cfg_psc),
        .cfg_arr(cfg_arr), .cfg_en(cfg_en), .cfg_filt_len(cfg_filt_len),
        .rd_stb(rd_stb), .rd_ack(rd_ack), .rd_hit(rd_hit), .rd_err(rd_err),
        .rd_data(rd_data)
    );

    // Reference counter built from R1.
    logic [CNT_W-1:0] m_cnt;
    logic [PSC_W-1:0] m_pre;

    function automatic void step(inout logic [CNT_W-1:0] c, inout logic [PSC_W-1:0] p);
        if (p == cfg_psc) begin
            p = '0;
            c = (c == cfg_arr) ? '0 : c + 1'b1;
        end else begin
            p = p + 1'b1;
        end
    endfunction

    function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c0,
                                                  input logic [PSC_W-1:0] p0, input int n);
        logic [CNT_W-1:0] c = c0;
        logic [PSC_W-1:0] p = p0;
        for (int i = 0; i < n; i++) step(c, p);
        return c;
    endfunction

    function automatic int eff() ;
        return (cfg_filt_len == 0) ? 1 : int'(cfg_filt_len);
    endfunction

    always @(posedge clk) begin
        logic [CNT_W-1:0] c;
        logic [PSC_W-1:0] p;
        if (!rst_n) begin
            m_cnt <= '0;
            m_pre <= '0;
        end else begin
            c = m_cnt;
            p = m_pre;
            step(c, p);
            m_cnt <= c;
            m_pre <= p;
        end
    end

    task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input int psc, input int arr, input int len, input logic en);
        @(negedge clk);
        rst_n = 1'b0;
        ref_in = 1'b0;
        rd_stb = 1'b0;
        cfg_psc = PSC_W'(psc);
        cfg_arr = CNT_W'(arr);
        cfg_filt_len = FLT_W'(len);
        cfg_en = en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a high pulse of w samples; returns the timestamp R2 predicts.
    task automatic pulse(input int w, output logic [CNT_W-1:0] exp);
        @(negedge clk);
        ref_in = 1'b1;
        exp = advance(m_cnt, m_pre, eff() + 1);
        repeat (w) @(negedge clk);
        ref_in = 1'b0;
        repeat (eff() + 4) @(negedge clk);
    endtask

    task automatic do_read(output logic a, output logic h, output logic e, output logic [CNT_W-1:0] d);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        a = rd_ack; h = rd_hit; e = rd_err; d = rd_data;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired, no requirement completed");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic a, h, e;
        logic [CNT_W-1:0] d, x, y;
        int unsigned seed_val;
        seed_val = $urandom(32'd20240607);

        // R10: outputs quiet in and after reset
        do_reset(0, 1000, 8, 1'b1);
        check("R10 ack", {31'd0, rd_ack}, 0);
        check("R10 hit", {31'd0, rd_hit}, 0);
        check("R10 err", {31'd0, rd_err}, 0);
        check("R10 data", rd_data, 0);

        // R5: empty read
        do_read(a, h, e, d);
        check("R5 ack", {31'd0, a}, 1);
        check("R5 hit", {31'd0, h}, 0);
        check("R5 data", d, 0);
        @(negedge clk);
        check("R5 ack one cycle", {31'd0, rd_ack}, 0);

        // R6/R2: single capture at exact filter length
        pulse(8, x);
        do_read(a, h, e, d);
        check("R6 hit", {31'd0, h}, 1);
        check("R6 err", {31'd0, e}, 0);
        check("R2 value", d, x);

        // R3: one sample too short
        pulse(7, x);
        do_read(a, h, e, d);
        check("R3 short pulse no hit", {31'd0, h}, 0);

        // R4: long pulse captures once, falling edge adds nothing
        pulse(15, x);
        do_read(a, h, e, d);
        check("R4 first read", d, x);
        do_read(a, h, e, d);
        check("R4 falling edge no hit", {31'd0, h}, 0);

        // R7: two captures without read
        pulse(9, x);
        pulse(9, y);
        do_read(a, h, e, d);
        check("R7 hit", {31'd0, h}, 1);
        check("R7 err", {31'd0, e}, 1);
        check("R7 newest value", d, y);
        do_read(a, h, e, d);
        check("R7 cleared hit", {31'd0, h}, 0);
        check("R7 cleared err", {31'd0, e}, 0);

        // R8: read on the capture edge
        pulse(8, x);
        @(negedge clk);
        ref_in = 1'b1;
        y = advance(m_cnt, m_pre, eff() + 1);
        repeat (eff() + 1) @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R8 hit", {31'd0, rd_hit}, 1);
        check("R8 err", {31'd0, rd_err}, 0);
        check("R8 older value", rd_data, x);
        ref_in = 1'b0;
        repeat (12) @(negedge clk);
        do_read(a, h, e, d);
        check("R8 new pending hit", {31'd0, h}, 1);
        check("R8 new pending err", {31'd0, e}, 0);
        check("R8 new value", d, y);

        // R9: disabled channel ignores edges
        do_reset(1, 500, 4, 1'b0);
        pulse(10, x);
        do_read(a, h, e, d);
        check("R9 disabled no hit", {31'd0, h}, 0);
        @(negedge clk);
        cfg_en = 1'b1;
        pulse(10, x);
        do_read(a, h, e, d);
        check("R9 enabled hit", {31'd0, h}, 1);
        check("R9 enabled value", d, x);

        // R1: wrap with prescale, zero filter length acts as one
        do_reset(2, 6, 0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            pulse(1 + i, x);
            do_read(a, h, e, d);
            check("R1 wrap hit", {31'd0, h}, 1);
            check("R1 wrap value", d, x);
        end

        // R1/R2/R3: random configurations and widths
        for (int k = 0; k < 5; k++) begin
            do_reset(int'($urandom % 4), 5 + int'($urandom % 36), int'($urandom % 9), 1'b1);
            for (int i = 0; i < 8; i++) begin
                int w;
                w = 1 + int'($urandom % 10);
                pulse(w, x);
                do_read(a, h, e, d);
                if (w >= eff()) begin
                    check("R3 random hit", {31'd0, h}, 1);
                    check("R2 random value", d, x);
                end else begin
                    check("R3 random no hit", {31'd0, h}, 0);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule